// File: doc/BRIEF.md
# Protected Memory Map Decoder

This block sits between a 68000-style CPU bus and the memories and peripherals of a 24-bit address map. For every access it takes the address, a write flag, the access size and the supervisor flag. It names the region the access falls in and gives the byte offset inside that region. It also tells the read path when the returned data must be forced to zero. The region decode is combinational in the cycle of the access. A fault is reported one clock later as a registered one-cycle pulse, together with a bit that says whether the faulting access was a write.

The map is built from 64 KiB banks, indexed by address bits [23:16]:

- Bank 0 is protected system RAM. The first 2 KiB of it can only be reached in supervisor mode, and its first 8 bytes cannot be written at all.
- Main RAM follows bank 0, up to the configured size.
- A silent void region runs from the end of RAM up to 4 MiB.
- A faulting hole runs from 4 MiB up to the ROM area.
- The top of the map holds the ROM, a cartridge window, an IDE window and an I/O window. The banks around them fault.
- The ROM sits at one of two bases. The window it does not use faults.

The RAM size, the ROM base and a 24-bit mirroring mode are configuration inputs. The block captures them on every clock edge while reset is held, and keeps them constant afterwards.

Top module: `memmap_guard`

## Requirements
- R1: Region codes on `region_sel` are: 0 system RAM (bank 0x00), 1 main RAM, 2 void, 3 ROM, 4 cartridge (banks 0xFA–0xFB), 5 IDE (bank 0xF0), 6 I/O (bank 0xFF), 7 fault. Banks 0xF1–0xF9 fault. The region comes from address bits [23:16], and the fixed top-of-map banks take precedence over RAM.
- R2: The RAM size input is captured on each clock edge while `rst_n` is low and is rounded up to a whole number of 64 KiB banks. Banks 1 up to (but not including) that bank count decode as main RAM.
- R3: An access in user mode (`acc_super`=0) to an address whose low 24 bits are below 0x800 faults, whether it is a read or a write. The same access in supervisor mode is allowed.
- R4: A write to an address whose low 24 bits are below 0x8 faults in both modes.
- R5: Above RAM and below 0x400000, accesses decode as void and never fault. A void read raises `rd_zero`; a void write raises nothing.
- R6: Every access from 0x400000 up to 0xDFFFFF faults.
- R7: With `cfg_rom_hi`=1, ROM occupies banks 0xFC–0xFE and banks 0xE0–0xEF fault. With `cfg_rom_hi`=0, ROM occupies banks 0xE0–0xEF and banks 0xFC–0xFE fault.
- R8: Reads of ROM and cartridge succeed. Writes to either region fault.
- R9: `berr_pulse` is high in the cycle after a valid access that faults, and low otherwise. `berr_write` is high only together with `berr_pulse`, and only when that access was a write. During the faulting access itself, `region_sel` reads 7 and `rd_zero` is high for a read.
- R10: With `cfg_addr24`=0, a nonzero address byte [31:24] faults. With `cfg_addr24`=1, that byte is ignored.
- R11: Size code 00 is a byte, 01 a word, and 10 or 11 a long. An access whose last byte decodes to a different region than its first byte faults, including a wrap past the top of the 24-bit space.
- R12: `region_off` is the address minus the region base: 0 for both RAM regions, the selected ROM base, 0xFA0000 for cartridge, 0xF00000 for IDE, 0xFF0000 for I/O. It is 0 for void and for fault.
- R13: While reset is held, `berr_pulse` and `berr_write` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration is captured while it is low |
| cfg_ram_bytes | input | 24 | RAM size in bytes |
| cfg_rom_hi | input | 1 | 1: ROM at 0xFC0000; 0: ROM at 0xE00000 |
| cfg_addr24 | input | 1 | 1: ignore address bits [31:24] |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for a write |
| acc_size | input | 2 | 00 byte, 01 word, 1x long |
| acc_super | input | 1 | Supervisor mode |
| acc_addr | input | 32 | Byte address |
| region_sel | output | 3 | Region code per R1 |
| region_off | output | 24 | Offset inside the region |
| rd_zero | output | 1 | Force the read data to zero |
| berr_pulse | output | 1 | Registered fault pulse |
| berr_write | output | 1 | Faulting access was a write |

## Verification
The bench probes the protection edges at 0x7/0x8 and 0x7FF/0x800. A wrong compare there would either let user code into the vector area or fault legal supervisor accesses. It uses a RAM size one byte past a bank boundary, which a design that truncates instead of rounding would turn into void. It swaps the ROM base, which a design with a fixed ROM window would decode wrongly. It issues long accesses that straddle a region end or the top of the 24-bit space; a design that forgets the last byte would silently wrap into another region. It also checks mirrored upper address bytes in both modes, and back-to-back faults against idle cycles, which catch a fault pulse that is stretched, dropped or carries the wrong write flag.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  localparam int ADDR_W = 32;
  localparam int MAP_W  = 24;

  typedef enum logic [2:0] {
    RG_SYS   = 3'd0,
    RG_RAM   = 3'd1,
    RG_VOID  = 3'd2,
    RG_ROM   = 3'd3,
    RG_CART  = 3'd4,
    RG_IDE   = 3'd5,
    RG_IO    = 3'd6,
    RG_FAULT = 3'd7
  } region_e;

  localparam logic [7:0] BK_IO        = 8'hFF;
  localparam logic [7:0] BK_IDE       = 8'hF0;
  localparam logic [7:0] BK_HOLE_LO   = 8'hF1;
  localparam logic [7:0] BK_HOLE_HI   = 8'hF9;
  localparam logic [7:0] BK_CART_LO   = 8'hFA;
  localparam logic [7:0] BK_CART_HI   = 8'hFB;
  localparam logic [7:0] BK_ROMH_LO   = 8'hFC;
  localparam logic [7:0] BK_ROMH_HI   = 8'hFE;
  localparam logic [7:0] BK_ROML_LO   = 8'hE0;
  localparam logic [7:0] BK_ROML_HI   = 8'hEF;
  localparam logic [7:0] BK_VOID_END  = 8'h40;

  localparam logic [MAP_W-1:0] SUPER_LIMIT = 24'h000800;
  localparam logic [MAP_W-1:0] WPROT_LIMIT = 24'h000008;

  // number of bytes touched by a size code
  function automatic logic [2:0] span_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // true when the last byte of the access lies in the next 64 KiB bank
  function automatic logic spills_bank(input logic [15:0] lo, input logic [2:0] span);
    return ({1'b0, lo} + {14'b0, span}) > 17'h10000;
  endfunction

  function automatic logic [MAP_W-1:0] region_base(input region_e r, input logic rom_hi);
    case (r)
      RG_ROM:  return rom_hi ? 24'hFC0000 : 24'hE00000;
      RG_CART: return 24'hFA0000;
      RG_IDE:  return 24'hF00000;
      RG_IO:   return 24'hFF0000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/memmap_cfg_latch.sv
module memmap_cfg_latch #(
  parameter int RAMSZ_W = 24,
  localparam int NB_W   = RAMSZ_W - 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RAMSZ_W-1:0] cfg_ram_bytes,
  input  logic               cfg_rom_hi,
  input  logic               cfg_addr24,
  output logic [NB_W-1:0]    ram_banks,
  output logic               rom_hi,
  output logic               addr24
);

  logic [RAMSZ_W:0] rounded;

  // round up to the next 64 KiB multiple; the bank count is the upper part
  assign rounded = {1'b0, cfg_ram_bytes} + (RAMSZ_W+1)'(17'h0FFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_banks <= rounded[RAMSZ_W:16];
      rom_hi    <= cfg_rom_hi;
      addr24    <= cfg_addr24;
    end
  end

endmodule

// File: rtl/memmap_bank_decode.sv
module memmap_bank_decode
  import memmap_pkg::*;
#(
  parameter int NB_W = 9
) (
  input  logic [7:0]      bank,
  input  logic            hi_ok,
  input  logic [NB_W-1:0] ram_banks,
  input  logic            rom_hi,
  output region_e         region
);

  logic in_ram;

  assign in_ram = {{(NB_W-8){1'b0}}, bank} < ram_banks;

  always_comb begin
    if (!hi_ok)                                          region = RG_FAULT;
    else if (bank == BK_IO)                              region = RG_IO;
    else if (bank == BK_IDE)                             region = RG_IDE;
    else if (bank >= BK_HOLE_LO && bank <= BK_HOLE_HI)   region = RG_FAULT;
    else if (bank >= BK_CART_LO && bank <= BK_CART_HI)   region = RG_CART;
    else if (bank >= BK_ROMH_LO && bank <= BK_ROMH_HI)   region = rom_hi ? RG_ROM : RG_FAULT;
    else if (bank >= BK_ROML_LO && bank <= BK_ROML_HI)   region = rom_hi ? RG_FAULT : RG_ROM;
    else if (bank == 8'h00)                              region = RG_SYS;
    else if (in_ram)                                     region = RG_RAM;
    else if (bank < BK_VOID_END)                         region = RG_VOID;
    else                                                 region = RG_FAULT;
  end

endmodule

// File: rtl/memmap_access_check.sv
module memmap_access_check
  import memmap_pkg::*;
#(
  parameter int NB_W = 9
) (
  input  logic              acc_write,
  input  logic              acc_super,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              addr24,
  input  logic              rom_hi,
  input  logic [NB_W-1:0]   ram_banks,
  output region_e           first_region,
  output region_e           sel,
  output logic [MAP_W-1:0]  offset,
  output logic              fault,
  output logic              prot_fault
);

  localparam int NPROBE = 2;

  logic [MAP_W-1:0] low24;
  logic [2:0]       span;
  logic             carry;
  logic [15:0]      probe_hi [NPROBE];
  region_e          probe_rg [NPROBE];
  logic             ro_write;
  logic             straddle;

  assign low24 = acc_addr[MAP_W-1:0];
  assign span  = span_bytes(acc_size);
  assign carry = spills_bank(acc_addr[15:0], span);

  assign probe_hi[0] = acc_addr[31:16];
  assign probe_hi[1] = acc_addr[31:16] + {15'b0, carry};

  // probe 0 decodes the first byte, probe 1 the last byte
  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    memmap_bank_decode #(.NB_W(NB_W)) u_dec (
      .bank      (probe_hi[g][7:0]),
      .hi_ok     (addr24 || (probe_hi[g][15:8] == 8'h00)),
      .ram_banks (ram_banks),
      .rom_hi    (rom_hi),
      .region    (probe_rg[g])
    );
  end

  assign first_region = probe_rg[0];

  // protection is evaluated before the region decode
  assign prot_fault = (!acc_super && (low24 < SUPER_LIMIT)) ||
                      (acc_write  && (low24 < WPROT_LIMIT));

  assign ro_write = acc_write && ((probe_rg[0] == RG_ROM) || (probe_rg[0] == RG_CART));
  assign straddle = (probe_rg[0] != probe_rg[1]);

  assign fault = prot_fault || (probe_rg[0] == RG_FAULT) || ro_write || straddle;
  assign sel   = fault ? RG_FAULT : probe_rg[0];

  always_comb begin
    if (sel == RG_VOID || sel == RG_FAULT) offset = '0;
    else                                   offset = low24 - region_base(sel, rom_hi);
  end

endmodule

// File: rtl/memmap_fault_pulse.sv
module memmap_fault_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic acc_write,
  input  logic fault,
  output logic berr_pulse,
  output logic berr_write
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr_pulse <= 1'b0;
      berr_write <= 1'b0;
    end else begin
      berr_pulse <= acc_valid && fault;
      berr_write <= acc_valid && fault && acc_write;
    end
  end

endmodule

// File: rtl/memmap_guard.sv
module memmap_guard
  import memmap_pkg::*;
#(
  parameter int RAMSZ_W = 24,
  localparam int NB_W   = RAMSZ_W - 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RAMSZ_W-1:0] cfg_ram_bytes,
  input  logic               cfg_rom_hi,
  input  logic               cfg_addr24,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [1:0]         acc_size,
  input  logic               acc_super,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [2:0]         region_sel,
  output logic [MAP_W-1:0]   region_off,
  output logic               rd_zero,
  output logic               berr_pulse,
  output logic               berr_write
);

  logic [NB_W-1:0] ram_banks;
  logic            rom_hi;
  logic            addr24;
  region_e         first_reg_e;
  region_e         sel_e;
  logic            fault;
  logic            prot_fault;
  logic [2:0]      first_region;

  memmap_cfg_latch #(.RAMSZ_W(RAMSZ_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ram_bytes (cfg_ram_bytes),
    .cfg_rom_hi    (cfg_rom_hi),
    .cfg_addr24    (cfg_addr24),
    .ram_banks     (ram_banks),
    .rom_hi        (rom_hi),
    .addr24        (addr24)
  );

  memmap_access_check #(.NB_W(NB_W)) u_chk (
    .acc_write    (acc_write),
    .acc_super    (acc_super),
    .acc_size     (acc_size),
    .acc_addr     (acc_addr),
    .addr24       (addr24),
    .rom_hi       (rom_hi),
    .ram_banks    (ram_banks),
    .first_region (first_reg_e),
    .sel          (sel_e),
    .offset       (region_off),
    .fault        (fault),
    .prot_fault   (prot_fault)
  );

  memmap_fault_pulse u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .fault      (fault),
    .berr_pulse (berr_pulse),
    .berr_write (berr_write)
  );

  assign first_region = first_reg_e;
  assign region_sel   = sel_e;
  assign rd_zero      = acc_valid && !acc_write &&
                        ((sel_e == RG_VOID) || (sel_e == RG_FAULT));

endmodule

// File: rtl/memmap_guard_sva.sv
module memmap_guard_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_super,
  input logic [31:0] acc_addr,
  input logic [2:0]  region_sel,
  input logic [23:0] region_off,
  input logic        rd_zero,
  input logic        berr_pulse,
  input logic        berr_write,
  input logic [2:0]  first_region,
  input logic        prot_fault
);

  // R9
  pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |-> $past(acc_valid));

  // R9
  write_flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |-> (berr_write == $past(acc_write)));

  // R9
  write_only_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_write |-> berr_pulse);

  // R3
  user_low_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_super && acc_addr[23:11] == 13'h0) |=> berr_pulse);

  // R4
  vector_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[23:3] == 21'h0) |=> (berr_pulse && berr_write));

  // R8
  rom_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && (first_region == 3'd3 || first_region == 3'd4))
      |=> (berr_pulse && berr_write));

  // R3
  prot_reports_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (region_sel == 3'd7));

  // R5
  zero_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> (acc_valid && !acc_write));

  // R12
  fault_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_sel == 3'd7 || region_sel == 3'd2) |-> (region_off == 24'h0));

endmodule

bind memmap_guard memmap_guard_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_super    (acc_super),
  .acc_addr     (acc_addr),
  .region_sel   (region_sel),
  .region_off   (region_off),
  .rd_zero      (rd_zero),
  .berr_pulse   (berr_pulse),
  .berr_write   (berr_write),
  .first_region (first_region),
  .prot_fault   (prot_fault)
);

// File: tb/memmap_guard_bench.sv
module memmap_guard_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cfg_ram_bytes = 24'h080000;
  logic        cfg_rom_hi = 1'b1;
  logic        cfg_addr24 = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic        acc_super = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic [2:0]  region_sel;
  logic [23:0] region_off;
  logic        rd_zero;
  logic        berr_pulse;
  logic        berr_write;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model configuration, set together with the reset sequence
  int m_ram_bytes = 'h80000;
  bit m_rom_hi = 1'b1;
  bit m_a24 = 1'b0;

  bit exp_pulse = 1'b0;
  bit exp_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_guard u_memmap_guard (
    .clk(clk), .rst_n(rst_n), .cfg_ram_bytes(cfg_ram_bytes), .cfg_rom_hi(cfg_rom_hi),
    .cfg_addr24(cfg_addr24), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_super(acc_super), .acc_addr(acc_addr),
    .region_sel(region_sel), .region_off(region_off), .rd_zero(rd_zero),
    .berr_pulse(berr_pulse), .berr_write(berr_write)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic longint ram_top();
    return ((longint'(m_ram_bytes) + 65535) / 65536) * 65536;
  endfunction

  // region of one byte address, from the address ranges of the map
  function automatic int model_raw(input logic [31:0] a);
    longint x;
    if (!m_a24 && a[31:24] != 8'h0) return 7;
    x = longint'(a[23:0]);
    if (x >= 'hFF0000) return 6;
    if (x >= 'hFC0000) return m_rom_hi ? 3 : 7;
    if (x >= 'hFA0000) return 4;
    if (x >= 'hF10000) return 7;
    if (x >= 'hF00000) return 5;
    if (x >= 'hE00000) return m_rom_hi ? 7 : 3;
    if (x <  'h10000)  return 0;
    if (x < ram_top()) return 1;
    if (x < 'h400000)  return 2;
    return 7;
  endfunction

  task automatic model_eval(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                            input bit sup, output int rg, output bit flt, output longint off);
    int n;
    int r0;
    logic [31:0] last;
    longint x;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    last = a + 32'(n - 1);
    x = longint'(a[23:0]);
    r0 = model_raw(a);
    flt = (!sup && x < 'h800) || (wr && x < 8) || (r0 == 7) ||
          (wr && (r0 == 3 || r0 == 4)) || (r0 != model_raw(last));
    rg = flt ? 7 : r0;
    case (rg)
      0, 1: off = x;
      3:    off = x - (m_rom_hi ? 'hFC0000 : 'hE00000);
      4:    off = x - 'hFA0000;
      5:    off = x - 'hF00000;
      6:    off = x - 'hFF0000;
      default: off = 0;
    endcase
  endtask

  // expected fault pulse, advanced with the design on every edge
  always @(posedge clk) begin : model_clk
    int rg;
    bit flt;
    longint off;
    if (!rst_n) begin
      exp_pulse <= 1'b0;
      exp_wr <= 1'b0;
    end else begin
      model_eval(acc_addr, acc_size, acc_write, acc_super, rg, flt, off);
      exp_pulse <= acc_valid && flt;
      exp_wr <= acc_valid && flt && acc_write;
    end
  end

  // R9 / R13: compare the registered pulse on every clock
  always @(negedge clk) begin
    if (!done) begin
      chk(rst_n ? "R9 berr_pulse" : "R13 berr_pulse in reset", berr_pulse, exp_pulse);
      chk(rst_n ? "R9 berr_write" : "R13 berr_write in reset", berr_write, exp_wr);
    end
  end

  task automatic apply_reset(input int ram, input bit rhi, input bit a24);
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    cfg_ram_bytes = 24'(ram);
    cfg_rom_hi = rhi;
    cfg_addr24 = a24;
    m_ram_bytes = ram;
    m_rom_hi = rhi;
    m_a24 = a24;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // configuration inputs move after reset; the design must keep its captured copy (R2)
    cfg_ram_bytes = 24'hFFFFFF;
    cfg_rom_hi = ~rhi;
    cfg_addr24 = ~a24;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input bit sup, input int exp_sel, input string tag);
    int rg;
    bit flt;
    longint off;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = a;
    acc_size = sz;
    acc_write = wr;
    acc_super = sup;
    #(CLK_PERIOD/4);
    model_eval(a, sz, wr, sup, rg, flt, off);
    if (exp_sel >= 0) chk({tag, " region_sel"}, region_sel, exp_sel);
    else              chk({tag, " region_sel"}, region_sel, rg);
    chk({tag, " region_off"}, region_off, off);
    chk({tag, " rd_zero"}, rd_zero, !wr && (rg == 2 || rg == 7));
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    acc_addr = $urandom;
    acc_write = $urandom;
    #(CLK_PERIOD/4);
    chk("R5 rd_zero idle", rd_zero, 0);
  endtask

  task automatic sweep(input int count);
    logic [31:0] bases [12];
    bases = '{32'h0, 32'h7F000, 32'h10000, 32'h3F0000, 32'h400000, 32'hDF0000,
              32'hE00000, 32'hF00000, 32'hF10000, 32'hFA0000, 32'hFC0000, 32'hFF0000};
    for (int i = 0; i < count; i++) begin
      logic [31:0] a;
      a = bases[$urandom % 12] + ($urandom % 32'h20000);
      if ($urandom % 4 == 0) a[31:24] = 8'($urandom);
      if ($urandom % 3 == 0) a[15:0] = 16'hFFFF - 16'($urandom % 4);
      access(a, 2'($urandom), 1'($urandom), 1'($urandom), -1, "R1 sweep");
      if ($urandom % 5 == 0) idle();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // configuration A: 512 KiB RAM, ROM high, upper byte must be zero
    apply_reset('h80000, 1'b1, 1'b0);
    access(32'h000400, 2'b00, 0, 0, 7, "R3 user read low");
    access(32'h000400, 2'b01, 0, 1, 0, "R3 super read low");
    access(32'h000004, 2'b00, 1, 1, 7, "R4 super write vector");
    access(32'h000008, 2'b01, 1, 1, 0, "R4 super write above vector");
    access(32'h000007, 2'b00, 1, 1, 7, "R4 last protected byte");
    access(32'h000800, 2'b01, 0, 0, 0, "R3 user at limit");
    access(32'h0007FF, 2'b00, 1, 0, 7, "R3 user write below limit");
    access(32'h020000, 2'b10, 0, 0, 1, "R1 main ram");
    access(32'h080000, 2'b01, 0, 0, 2, "R5 void read");
    access(32'h100000, 2'b10, 1, 0, 2, "R5 void write");
    idle();
    access(32'h3FFFFE, 2'b01, 0, 0, 2, "R6 void top");
    access(32'h400000, 2'b01, 0, 1, 7, "R6 hole start");
    access(32'hDFFFFE, 2'b01, 1, 1, 7, "R6 hole end");
    access(32'hFC0010, 2'b01, 0, 0, 3, "R7 rom high read");
    access(32'hFC0010, 2'b01, 1, 1, 7, "R8 rom write");
    access(32'hE00000, 2'b01, 0, 1, 7, "R7 unused low rom");
    access(32'hFA1234, 2'b00, 0, 0, 4, "R8 cart read");
    access(32'hFA1234, 2'b00, 1, 1, 7, "R8 cart write");
    access(32'hF00020, 2'b01, 0, 1, 5, "R12 ide");
    access(32'hFF8800, 2'b01, 1, 1, 6, "R12 io");
    access(32'hF10000, 2'b00, 0, 1, 7, "R1 hole low");
    access(32'hF9FFFF, 2'b00, 0, 1, 7, "R1 hole high");
    access(32'h01000400, 2'b01, 0, 1, 7, "R10 upper byte");
    access(32'h07FFFE, 2'b10, 0, 0, 7, "R11 ram end straddle");
    access(32'h07FFFE, 2'b01, 0, 0, 1, "R11 ram end word");
    idle();
    sweep(500);

    // configuration B: RAM one byte past a bank, ROM low, mirrored upper byte
    apply_reset('h80001, 1'b0, 1'b1);
    access(32'h08FFFC, 2'b10, 0, 0, 1, "R2 rounded bank");
    access(32'h090000, 2'b01, 0, 0, 2, "R2 past rounded");
    access(32'hE00100, 2'b01, 0, 0, 3, "R7 rom low read");
    chk("R12 rom offset", region_off, 'h100);
    access(32'hFC0000, 2'b01, 0, 1, 7, "R7 unused high rom");
    access(32'h01FF8800, 2'b01, 0, 1, 6, "R10 mirrored io");
    access(32'hAB000400, 2'b01, 0, 0, 7, "R10 mirrored protect");
    access(32'h00FFFFFE, 2'b10, 0, 1, 7, "R11 top wrap");
    idle();
    sweep(500);

    // configuration C: no RAM beyond bank 0
    apply_reset(0, 1'b1, 1'b1);
    access(32'h010000, 2'b01, 0, 0, 2, "R2 empty ram");
    sweep(300);
    idle();
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule